// File: doc/BRIEF.md
# SD serial five-fold bit repeater

This block lets a transceiver that cannot run at the standard-definition serial rate still carry that stream. The lane runs at 1350 Mbps. Each payload bit is sent five times in a row, so the line carries 270 Mbps of real data. A 20-bit parallel word is accepted once every five core clocks. On each core clock the block presents a 20-bit transceiver word. That word holds four payload bits, and each of them appears five times.

A five-state phase sequencer cycles through `PH0`, `PH1`, `PH2`, `PH3`, `PH4` and returns to `PH0`. Every transition is unconditional, one per clock: `PH0->PH1`, `PH1->PH2`, `PH2->PH3`, `PH3->PH4` and `PH4->PH0`. Reset places the sequencer in `PH0`. A load strobe is only valid in `PH0`. A strobe in any other state is refused and raises a sticky misalignment flag. Scrambling, NRZI coding and serialisation take place elsewhere.

Top module: `sd_tx_bitrep`

## Requirements
- R1: While reset is asserted and right after it is released, `line_word` is all zeros and `align_err` is 0.
- R2: The phase sequencer starts in PH0 on the first clock edge after reset is released. It then advances one state per edge, PH0 to PH4, and wraps to PH0, so a PH0 edge occurs every fifth edge.
- R3: A strobe at a PH0 edge captures `tx_word`. After that edge, `line_word[5i+4:5i]` equals five copies of `tx_word[i]` for i = 0..3.
- R4: On the four edges that follow the capture (PH1 to PH4), group k of the word (k = 1..4) is shown. `line_word[5i+4:5i]` holds five copies of captured bit 4k+i.
- R5: The payload goes out least significant bit first. Captured bit 0 fills `line_word[4:0]`, and `line_word` bit 0 is the first bit on the wire.
- R6: At a PH0 edge with no strobe, `line_word` becomes all zeros for the whole five-clock slot. This also holds from reset until the first strobe.
- R7: A strobe at a PH1 to PH4 edge is ignored and has no effect on `line_word`, which keeps the current slot's sequence. On the following edge `align_err` becomes 1.
- R8: Once set, `align_err` stays 1 until reset.
- R9: Strobes on consecutive PH0 edges, five clocks apart, produce a continuous stream with no gap or repeated group between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | 20 | Parallel payload word |
| tx_load | input | 1 | Word strobe, valid in PH0 only |
| line_word | output | 20 | Five-fold repeated transceiver word, bit 0 sent first |
| align_err | output | 1 | Sticky flag: a strobe arrived outside PH0 |

## Verification
The bench builds the block with its default shape: a 20-bit word and a repeat factor of five, which gives four payload bits per clock and a five-state sequence. With these values every group position and every state can be reached within a few slots. Single-bit and top-bit words therefore pin down the bit-to-lane mapping. A misaligned strobe can be placed in each of the four non-zero states in turn, and the flag's persistence can be followed through hundreds of random PH0 slots.

// File: rtl/sdrep_pkg.sv
package sdrep_pkg;
    localparam int WORD_W       = 20;
    localparam int REP          = 5;
    localparam int BITS_PER_CLK = WORD_W / REP;
    localparam int PHASES       = WORD_W / BITS_PER_CLK;

    typedef enum logic [2:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4
    } phase_e;
endpackage

// File: rtl/sdrep_phase_fsm.sv
module sdrep_phase_fsm
    import sdrep_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);
    phase_e phase_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH0;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx = PH0;
        unique case (phase)
            PH0: phase_nx = PH1;
            PH1: phase_nx = PH2;
            PH2: phase_nx = PH3;
            PH3: phase_nx = PH4;
            PH4: phase_nx = PH0;
            default: phase_nx = PH0;
        endcase
    end

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH4) |=> (phase == PH0));
endmodule

// File: rtl/sdrep_word_hold.sv
module sdrep_word_hold
    import sdrep_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int G = BITS_PER_CLK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic [G-1:0] group
);
    localparam int REST_W = W - G;

    logic [REST_W-1:0] rest;
    logic              take;

    assign take  = load && (phase == PH0);
    assign group = take ? word[G-1:0] : rest[G-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rest <= '0;
        else if (take) rest <= word[W-1:G];
        else           rest <= rest >> G;
    end
endmodule

// File: rtl/sdrep_spreader.sv
module sdrep_spreader
    import sdrep_pkg::*;
#(
    parameter int G = BITS_PER_CLK,
    parameter int R = REP
) (
    input  logic [G-1:0]   group,
    output logic [G*R-1:0] lanes
);
    for (genvar b = 0; b < G; b++) begin : g_bit
        assign lanes[b*R +: R] = {R{group[b]}};
    end
endmodule

// File: rtl/sd_tx_bitrep.sv
module sd_tx_bitrep
    import sdrep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic [WORD_W-1:0] line_word,
    output logic              align_err
);
    phase_e                  phase;
    logic [BITS_PER_CLK-1:0] group;
    logic [WORD_W-1:0]       lanes;

    sdrep_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    sdrep_word_hold #(.W(WORD_W), .G(BITS_PER_CLK)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .load  (tx_load),
        .word  (tx_word),
        .group (group)
    );

    sdrep_spreader #(.G(BITS_PER_CLK), .R(REP)) u_spread (
        .group (group),
        .lanes (lanes)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_word <= '0;
            align_err <= 1'b0;
        end else begin
            line_word <= lanes;
            if (tx_load && (phase != PH0)) align_err <= 1'b1;
        end
    end

    // R7
    misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && phase != PH0) |=> align_err);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH0 && !tx_load) |=> (line_word == '0));
endmodule

// File: tb/sd_tx_bitrep_bench.sv
module sd_tx_bitrep_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] tx_word = '0;
    logic        tx_load = 1'b0;
    logic [19:0] line_word;
    logic        align_err;

    int checks = 0;
    int fails  = 0;
    int ph     = 0;
    logic [19:0] cur = '0;
    logic [19:0] exp_out = '0;
    logic        exp_err = 1'b0;
    bit          done = 0;

    always #10 clk = ~clk;

    sd_tx_bitrep u_sd_tx_bitrep (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_load(tx_load),
        .line_word(line_word), .align_err(align_err)
    );

    function automatic logic [19:0] rep5(input logic [3:0] n);
        logic [19:0] o;
        for (int i = 0; i < 20; i++) o[i] = n[i/5];
        return o;
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    // drive at negedge, model the edge, compare at the next negedge
    task automatic step(input logic ld, input logic [19:0] w, input string req);
        tx_load = ld;
        tx_word = w;
        @(posedge clk);
        if (ph == 0) begin
            cur = ld ? w : 20'h0;
            exp_out = rep5(cur[3:0]);
        end else begin
            exp_out = rep5(cur[4*ph +: 4]);
            if (ld) exp_err = 1'b1;
        end
        ph = (ph + 1) % 5;
        @(negedge clk);
        tx_load = 1'b0;
        check(req, line_word, exp_out);
        check("R8", {19'h0, align_err}, {19'h0, exp_err});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_load = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", line_word, 20'h0);
        check("R1", {19'h0, align_err}, 20'h0);
        rst_n = 1'b1;
        ph = 0; cur = '0; exp_out = '0; exp_err = 1'b0;
    endtask

    task automatic send(input logic [19:0] w, input string req);
        step(1'b1, w, req);
        for (int k = 1; k < 5; k++) step(1'b0, 20'h0, "R4");
    endtask

    initial begin
        void'($urandom(32'h5D1_0270));
        @(negedge clk);
        do_reset();
        // R2 / R6: idle slots stay zero
        for (int i = 0; i < 10; i++) step(1'b0, 20'h0, "R6");
        // R3 / R5: lowest bit lands on lanes 4:0
        step(1'b1, 20'h00001, "R5");
        check("R5", line_word, 20'h0001F);
        for (int k = 1; k < 5; k++) step(1'b0, 20'h0, "R4");
        // R4: top bit appears in the last group, top lanes
        send(20'h80000, "R3");
        check("R4", line_word, 20'hF8000);
        // R9: back-to-back words
        send(20'hFFFFF, "R9");
        send(20'hA5C3E, "R9");
        send(20'h12345, "R9");
        step(1'b0, 20'h0, "R6");
        for (int k = 1; k < 5; k++) step(1'b0, 20'h0, "R6");
        // random PH0 slots
        for (int s = 0; s < 300; s++) begin
            logic ld;
            ld = ($urandom % 4) != 0;
            step(ld, 20'($urandom), "R3");
            for (int k = 1; k < 5; k++) step(1'b0, 20'($urandom), "R4");
        end
        // R7: misaligned strobes in each nonzero state are ignored
        for (int p = 1; p < 5; p++) begin
            step(1'b1, 20'h3C96A, "R3");
            for (int k = 1; k < 5; k++) step(k == p, 20'($urandom), "R7");
        end
        for (int i = 0; i < 50; i++) step(1'b0, 20'h0, "R8");
        // R1 / R8: reset clears the flag
        do_reset();
        step(1'b0, 20'h0, "R1");
        send(20'h0F0F0, "R3");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule